// File: doc/BRIEF.md
# Prioritized Interrupt-Level Aggregator

This block collects thirteen level-sensitive interrupt lines from board peripherals and turns them into a single 4-bit encoded interrupt-request level for a processor. Each line owns one bit of a 16-bit status word that tracks the line's current level. A software-writable enable word gates that status. Among the lines that are both active and enabled, the one with the most urgent fixed rank wins. Its rank is inverted before it drives the level output, so an all-zero output means nothing is pending and rank 0 drives all ones.

Every line has two fixed properties: a rank and a bit position in the status and enable words. The two are independent of each other. The same block holds a small 16-bit register window on a single-cycle synchronous bus: the enable word, a general-purpose output latch, a constant identification register and a write-triggered power-down request. Lines are never latched or cleared here. A line that drops stops being pending at once.

Top module: `irl_aggregator`

## Requirements
- R1: After reset the enable word and the output latch read 0x0000, `level_o` is 0 and `off_req_o` is 0.
- R2: Input `src_i[n]` has rank n. It is routed to one bit of the status and enable words as follows: rank 0 to bit 11, rank 1 to bit 9, rank 2 to bit 8, rank 3 to bit 12, rank 4 to bit 10, rank 5 to bit 6, rank 6 to bit 5, rank 7 to bit 4, rank 8 to bit 7, rank 9 to bit 14, rank 10 to bit 13, rank 11 to bit 0 and rank 12 to bit 15. Enable bits 1, 2 and 3 gate nothing.
- R3: A line is pending when its input is high and its enable bit is 1. `level_o` equals 15 minus the smallest pending rank, or 0 when no line is pending.
- R4: `level_o` is registered. It takes the value implied by `src_i` one clock edge after that input is sampled. It takes the value implied by a new enable word one edge after the edge that stores the write, so on the write edge itself it still shows the old value.
- R5: Word address 0x00 (byte offset 0x00) holds the enable word. All 16 bits are written by `wr_i` and read back by `rd_i`.
- R6: Word address 0x1B (byte offset 0x36) is an output latch. It reads back the last 16-bit value written and has no effect on `level_o`.
- R7: Word address 0x19 (byte offset 0x32) always reads 0x0010 and ignores writes.
- R8: Word address 0x18 (byte offset 0x30) reads 0x0000. A write with data bit 0 set drives `off_req_o` high for exactly the one cycle after the write edge. A write with bit 0 clear leaves `off_req_o` low.
- R9: `rdata_o` is 0x0000 whenever `rd_i` is low, and it is 0x0000 for a read of any word address other than 0x00, 0x18, 0x19 and 0x1B.
- R10: When a pending line drops, it stops contributing on the next edge, and `level_o` falls back to the next pending rank, or to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 13 | Interrupt lines, index equals rank |
| addr_i | input | 5 | Word address (byte offset divided by two) |
| wdata_i | input | 16 | Write data |
| wr_i | input | 1 | Write strobe, one access per cycle |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 16 | Read data, valid in the cycle `rd_i` is high |
| level_o | output | 4 | Inverted winning rank, 0 when idle |
| off_req_o | output | 1 | One-cycle power-down request |

## Verification
The bench walks a single active line through every rank with all lines enabled. A design that confused rank with bit position, or that forgot the final inversion, gives a wrong code on almost every one of those steps. With several lines active at once, a design that let the highest rank win instead of the lowest is caught. Clearing the enable bits of the two most urgent lines checks that gating uses the routed bit position; routing by index would disable the wrong lines. The bench also samples `level_o` on the same edge that stores a new enable word, which catches a design whose output moves early or late. It writes the identification register and reads it back, catching a design that stores the write. It issues a power-down write with bit 0 clear, catching a design that pulses on any write to that address.

// File: rtl/irl_agg_pkg.sv
package irl_agg_pkg;

    localparam int N_SRC   = 13;
    localparam int WORD_W  = 16;
    localparam int LVL_W   = 4;
    localparam int WADDR_W = 5;

    localparam logic [WADDR_W-1:0] WA_ENABLE = 5'h00;
    localparam logic [WADDR_W-1:0] WA_POWER  = 5'h18;
    localparam logic [WADDR_W-1:0] WA_IDENT  = 5'h19;
    localparam logic [WADDR_W-1:0] WA_LATCH  = 5'h1B;

    localparam logic [WORD_W-1:0] IDENT_VALUE = 16'h0010;

    typedef enum logic [2:0] {
        SEL_ENABLE,
        SEL_POWER,
        SEL_IDENT,
        SEL_LATCH,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic                wr;
        logic                rd;
        reg_sel_e            sel;
        logic [WORD_W-1:0]   data;
    } bus_req_t;

    // Bit position in the status / enable word owned by the line of rank idx.
    function automatic int route_bit(input int idx);
        case (idx)
            0:       route_bit = 11;
            1:       route_bit = 9;
            2:       route_bit = 8;
            3:       route_bit = 12;
            4:       route_bit = 10;
            5:       route_bit = 6;
            6:       route_bit = 5;
            7:       route_bit = 4;
            8:       route_bit = 7;
            9:       route_bit = 14;
            10:      route_bit = 13;
            11:      route_bit = 0;
            default: route_bit = 15;
        endcase
    endfunction

    function automatic reg_sel_e decode_addr(input logic [WADDR_W-1:0] a);
        case (a)
            WA_ENABLE: decode_addr = SEL_ENABLE;
            WA_POWER:  decode_addr = SEL_POWER;
            WA_IDENT:  decode_addr = SEL_IDENT;
            WA_LATCH:  decode_addr = SEL_LATCH;
            default:   decode_addr = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/irl_src_map.sv
module irl_src_map
    import irl_agg_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int WIDTH = WORD_W
) (
    input  logic [NSRC-1:0]  src_i,
    output logic [WIDTH-1:0] status_o
);

    // Scatter each line onto its routed bit; unrouted bits stay zero.
    always_comb begin
        status_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            status_o[route_bit(i)] = src_i[i];
        end
    end

endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc
    import irl_agg_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int WIDTH = WORD_W,
    parameter int LW    = LVL_W
) (
    input  logic [WIDTH-1:0] pend_i,
    output logic [LW-1:0]    code_o
);

    logic [LW-1:0] win;

    // Scan from least to most urgent so the smallest pending rank is last to win.
    always_comb begin
        win = '1;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[route_bit(i)]) begin
                win = LW'(i);
            end
        end
        code_o = win ^ {LW{1'b1}};
    end

endmodule

// File: rtl/irl_regfile.sv
module irl_regfile
    import irl_agg_pkg::*;
#(
    parameter int AW    = WADDR_W,
    parameter int WIDTH = WORD_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             wr_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [WIDTH-1:0] enable_o,
    output logic             off_req_o
);

    bus_req_t          req;
    logic [WIDTH-1:0]  enable_q;
    logic [WIDTH-1:0]  latch_q;
    logic              off_q;

    always_comb begin
        req.wr   = wr_i;
        req.rd   = rd_i;
        req.sel  = decode_addr(addr_i);
        req.data = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= '0;
            latch_q  <= '0;
            off_q    <= 1'b0;
        end else begin
            off_q <= req.wr && (req.sel == SEL_POWER) && req.data[0];
            if (req.wr && req.sel == SEL_ENABLE) begin
                enable_q <= req.data;
            end
            if (req.wr && req.sel == SEL_LATCH) begin
                latch_q <= req.data;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (req.rd) begin
            case (req.sel)
                SEL_ENABLE: rdata_o = enable_q;
                SEL_LATCH:  rdata_o = latch_q;
                SEL_IDENT:  rdata_o = IDENT_VALUE;
                default:    rdata_o = '0;
            endcase
        end
    end

    assign enable_o  = enable_q;
    assign off_req_o = off_q;

endmodule

// File: rtl/irl_aggregator.sv
module irl_aggregator
    import irl_agg_pkg::*;
#(
    parameter int NSRC  = N_SRC,
    parameter int WIDTH = WORD_W,
    parameter int LW    = LVL_W,
    parameter int AW    = WADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             wr_i,
    input  logic             rd_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [LW-1:0]    level_o,
    output logic             off_req_o
);

    logic [WIDTH-1:0] status_w;
    logic [WIDTH-1:0] enable_w;
    logic [WIDTH-1:0] pend_w;
    logic [LW-1:0]    code_w;
    logic [LW-1:0]    level_q;

    irl_src_map #(.NSRC(NSRC), .WIDTH(WIDTH)) map_i (
        .src_i    (src_i),
        .status_o (status_w)
    );

    irl_regfile #(.AW(AW), .WIDTH(WIDTH)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .wr_i      (wr_i),
        .rd_i      (rd_i),
        .rdata_o   (rdata_o),
        .enable_o  (enable_w),
        .off_req_o (off_req_o)
    );

    assign pend_w = status_w & enable_w;

    irl_prio_enc #(.NSRC(NSRC), .WIDTH(WIDTH), .LW(LW)) enc_i (
        .pend_i (pend_w),
        .code_o (code_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
        end else begin
            level_q <= code_w;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/irl_aggregator_chk.sv
module irl_aggregator_chk
    import irl_agg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [WADDR_W-1:0] addr_i,
    input logic [WORD_W-1:0]  wdata_i,
    input logic               wr_i,
    input logic               rd_i,
    input logic [WORD_W-1:0]  rdata_o,
    input logic [LVL_W-1:0]   level_o,
    input logic               off_req_o,
    input logic [WORD_W-1:0]  enable_w
);

    AST_IDENT_CONST: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == WA_IDENT) |-> rdata_o == IDENT_VALUE); // R7

    AST_POWER_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == WA_POWER) |-> rdata_o == '0); // R8

    AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        off_req_o |-> $past(wr_i && addr_i == WA_POWER && wdata_i[0])); // R8

    AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (rst)
        ($past(enable_w) == '0) |-> level_o == '0); // R3

    AST_LATCH_READBACK: assert property (@(posedge clk) disable iff (rst)
        (rd_i && addr_i == WA_LATCH && $past(wr_i && addr_i == WA_LATCH))
        |-> rdata_o == $past(wdata_i)); // R6

    AST_NO_READ_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        !rd_i |-> rdata_o == '0); // R9

endmodule

bind irl_aggregator irl_aggregator_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .wr_i      (wr_i),
    .rd_i      (rd_i),
    .rdata_o   (rdata_o),
    .level_o   (level_o),
    .off_req_o (off_req_o),
    .enable_w  (enable_w)
);

// File: tb/irl_aggregator_tb_top.sv
module irl_aggregator_tb_top;

    typedef struct {
        int          kind;   // 0 level_o, 1 rdata_o, 2 off_req_o
        logic [15:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] src = '0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [15:0] rdata;
    logic [3:0]  level;
    logic        offreq;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    item_t sb[$];

    logic [15:0] model_en = '0;

    always #4 clk = ~clk;

    irl_aggregator dut_i (
        .clk       (clk),
        .rst       (rst),
        .src_i     (src),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .wr_i      (wr),
        .rd_i      (rd),
        .rdata_o   (rdata),
        .level_o   (level),
        .off_req_o (offreq)
    );

    // Bench-side routing table from the requirement text.
    function automatic int bit_of(input int rank);
        int t[13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};
        return t[rank];
    endfunction

    function automatic logic [15:0] model_level(input logic [12:0] s, input logic [15:0] en);
        for (int r = 0; r < 13; r++) begin
            if (s[r] && en[bit_of(r)]) return 16'(15 - r);
        end
        return 16'd0;
    endfunction

    task automatic push(input int kind, input logic [15:0] exp, input string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb.push_back(it);
    endtask

    // Monitor: compares after the edge following each push.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = {12'd0, level};
                    1:       act = rdata;
                    default: act = {15'd0, offreq};
                endcase
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic set_src(input logic [12:0] v, input string req);
        @(negedge clk);
        src = v;
        push(0, model_level(v, model_en), req);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        if (a == 5'h00) begin
            // On the storing edge the level still reflects the old enable word (R4).
            push(0, model_level(src, model_en), "R4");
            model_en = d;
        end
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [15:0] exp, input string req);
        @(negedge clk);
        addr = a; rd = 1'b1;
        push(1, exp, req);
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(5'h00, 16'h0000, "R1");
        rd_reg(5'h1B, 16'h0000, "R1");
        @(negedge clk);
        push(0, 16'h0, "R1");
        push(2, 16'h0, "R1");

        // R3: lines active while everything is disabled
        set_src(13'h1FFF, "R3");
        set_src(13'h0000, "R3");

        // R5 enable word
        wr_reg(5'h00, 16'hFFFF);
        rd_reg(5'h00, 16'hFFFF, "R5");

        // R2 / R3 each rank alone
        for (int r = 0; r < 13; r++) begin
            set_src(13'(1 << r), "R2");
        end

        // R3 priority with several lines
        set_src(13'h1FFF, "R3");
        set_src(13'h1220, "R3");
        set_src(13'h1800, "R3");

        // R3 gating by routed bit: disable ranks 0 and 1
        set_src(13'h1FFF, "R3");
        wr_reg(5'h00, 16'hFFFF & ~16'h0A00);
        @(negedge clk);
        push(0, 16'd13, "R3");

        // R4 source path: change visible one edge later
        set_src(13'h0010, "R4");

        // R10 drop back
        set_src(13'h0110, "R10");
        set_src(13'h0010, "R10");
        set_src(13'h0000, "R10");

        // R6 output latch
        set_src(13'h0004, "R6");
        wr_reg(5'h1B, 16'hA5C3);
        rd_reg(5'h1B, 16'hA5C3, "R6");
        @(negedge clk);
        push(0, 16'd13, "R6");

        // R7 identification register
        rd_reg(5'h19, 16'h0010, "R7");
        wr_reg(5'h19, 16'hFFFF);
        rd_reg(5'h19, 16'h0010, "R7");

        // R8 power-down
        rd_reg(5'h18, 16'h0000, "R8");
        @(negedge clk);
        addr = 5'h18; wdata = 16'h0001; wr = 1'b1;
        push(2, 16'h1, "R8");
        @(negedge clk);
        wr = 1'b0;
        push(2, 16'h0, "R8");
        @(negedge clk);
        addr = 5'h18; wdata = 16'hFFFE; wr = 1'b1;
        push(2, 16'h0, "R8");
        @(negedge clk);
        wr = 1'b0;

        // R9 other addresses and idle read data
        rd_reg(5'h05, 16'h0000, "R9");
        rd_reg(5'h1F, 16'h0000, "R9");
        @(negedge clk);
        addr = 5'h00;
        push(1, 16'h0000, "R9");

        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule